// File: doc/BRIEF.md
# Shadowed Per-Channel Configuration Registers

This block keeps, for each receive channel, a set of working configuration words that software may write at any time, plus a second, shadow set that the downstream datapath actually consumes. The working set holds a configuration word (virtual channel, data format, full-gap threshold), a resolution word and a sync-interval word. Changing the working set has no effect on the datapath until software asks for an update.

An update is requested through per-channel strobe bits in a common control word. The block records an accepted request as a pending flag. It copies working into shadow when that channel signals end of frame, so a frame in flight never sees a half-changed configuration. A per-channel force bit lets the copy happen without waiting for the frame to end. A write-only soft-reset bit returns every register and every pending request to zero. A simple single-cycle write port and a combinational read port give access to all words, including the read-only shadow copies.

Top module: `shadow_cfg_regs`

## Requirements
- R1: After reset every working word, shadow word, force bit, enable bit and pending flag is 0, and every address reads 0.
- R2: A working configuration word keeps only bits [1:0] (virtual channel), [7:2] (data format) and [31:24] (full-gap threshold), with bits [23:8] reading 0; the resolution word keeps all 32 bits; the sync word keeps bits [23:0] and reads 0 above them.
- R3: Shadow words (word address 0x40 + 4*ch + {0 cfg, 1 resolution, 2 sync}) are read-only: a write to them changes nothing.
- R4: A strobe bit in the common word (address 0x00, bit 8+ch) is accepted only when the same write sets the enable bit (bit 0); otherwise no request is recorded and no copy happens.
- R5: An accepted strobe sets that channel's pending flag, which reads back at common-word bit 8+ch from the next cycle.
- R6: With a request pending, the enable bit set and the force bit clear, the copy happens at the clock edge where that channel's end-of-frame input is high, and the pending flag clears there; end of frame on another channel does not copy this one.
- R7: Writes to the working words while a request is pending do not cancel it; the shadow receives the working values held at the copy.
- R8: With force bit ch set (address 0x01, bit ch), a pending request copies at the next clock edge without any end-of-frame pulse.
- R9: Clearing the enable bit stalls a pending request: end-of-frame pulses do not copy it, and it stays pending until the enable bit is set again.
- R10: Writing 1 to common-word bit 1 clears every register and pending flag at the next edge, overriding any other bit of that write; this bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| eof_i | input | NUM_CH | Per-channel end-of-frame pulse |
| sh_cfg_o | output | NUM_CH*32 | Shadow configuration words to datapath |
| sh_res_o | output | NUM_CH*32 | Shadow resolution words to datapath |
| sh_sync_o | output | NUM_CH*32 | Shadow sync words to datapath |

## Verification
A wrong pending flag shows on the common word one cycle after the strobe write, and then as a shadow word that either changes at the wrong end-of-frame edge or never changes; each of these is read back at the negative edge right after the edge concerned. A shadow set copied from stale working state shows as a mismatch at the first shadow read after the copy edge. A soft reset that misses a register leaves a nonzero word visible one cycle after the reset write.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;

    localparam int DW = 32;

    // word address layout
    localparam int COMMON_ADDR = 'h00;
    localparam int FORCE_ADDR  = 'h01;
    localparam int WORK_BASE   = 'h10;
    localparam int SHAD_BASE   = 'h40;
    localparam int CH_STRIDE   = 4;

    // word index inside a channel window
    localparam int IDX_CFG  = 0;
    localparam int IDX_RES  = 1;
    localparam int IDX_SYNC = 2;

    // common word bit positions
    localparam int EN_BIT     = 0;
    localparam int SRST_BIT   = 1;
    localparam int STROBE_LSB = 8;

    localparam logic [DW-1:0] CFG_MASK  = 32'hFF00_00FF;
    localparam logic [DW-1:0] RES_MASK  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] SYNC_MASK = 32'h00FF_FFFF;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] res;
        logic [DW-1:0] sync;
    } cfg_set_t;

    function automatic int word_addr(input int base, input int ch, input int idx);
        return base + ch * CH_STRIDE + idx;
    endfunction

endpackage

// File: rtl/shcfg_ctrl.sv
module shcfg_ctrl
    import shcfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              en_o,
    output logic [NUM_CH-1:0] force_o,
    output logic              srst_o,
    output logic [NUM_CH-1:0] strobe_o
);

    localparam logic [ADDR_W-1:0] A_COMMON = ADDR_W'(COMMON_ADDR);
    localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(FORCE_ADDR);

    typedef struct packed {
        logic              en;
        logic [NUM_CH-1:0] frc;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     common_wr, force_wr;

    wire unused_bits = ^{wr_data[DW-1:STROBE_LSB+NUM_CH], wr_data[STROBE_LSB-1:SRST_BIT+1]};

    always_comb begin
        common_wr = wr_en && (wr_addr == A_COMMON);
        force_wr  = wr_en && (wr_addr == A_FORCE);
        srst_o    = common_wr && wr_data[SRST_BIT];
        strobe_o  = '0;
        if (common_wr && wr_data[EN_BIT] && !wr_data[SRST_BIT]) begin
            strobe_o = wr_data[STROBE_LSB +: NUM_CH];
        end

        st_d = st_q;
        if (common_wr) begin
            st_d.en = wr_data[EN_BIT];
        end
        if (force_wr) begin
            st_d.frc = wr_data[NUM_CH-1:0];
        end
        if (srst_o) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign force_o = st_q.frc;

endmodule

// File: rtl/shcfg_chan.sv
module shcfg_chan
    import shcfg_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              strobe_i,
    input  logic              force_i,
    input  logic              en_i,
    input  logic              eof_i,
    output cfg_set_t          work_o,
    output cfg_set_t          shad_o,
    output logic              pend_o
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(word_addr(WORK_BASE, CH_IDX, IDX_CFG));
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(word_addr(WORK_BASE, CH_IDX, IDX_RES));
    localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(word_addr(WORK_BASE, CH_IDX, IDX_SYNC));

    typedef struct packed {
        cfg_set_t work;
        cfg_set_t shad;
        logic     pend;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     copy_now;

    always_comb begin
        st_d     = st_q;
        copy_now = st_q.pend && en_i && (eof_i || force_i);

        if (wr_en && wr_addr == A_CFG) begin
            st_d.work.cfg = wr_data & CFG_MASK;
        end
        if (wr_en && wr_addr == A_RES) begin
            st_d.work.res = wr_data & RES_MASK;
        end
        if (wr_en && wr_addr == A_SYNC) begin
            st_d.work.sync = wr_data & SYNC_MASK;
        end

        // the copy takes the working set held at the start of this cycle
        if (copy_now) begin
            st_d.shad = st_q.work;
            st_d.pend = 1'b0;
        end
        if (strobe_i) begin
            st_d.pend = 1'b1;
        end
        if (srst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign work_o = st_q.work;
    assign shad_o = st_q.shad;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/shcfg_rdmux.sv
module shcfg_rdmux
    import shcfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic                       en_i,
    input  logic [NUM_CH-1:0]          force_i,
    input  logic [NUM_CH-1:0]          pend_i,
    input  cfg_set_t [NUM_CH-1:0]      work_i,
    input  cfg_set_t [NUM_CH-1:0]      shad_i,
    output logic [DW-1:0]              rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(COMMON_ADDR)) begin
            rd_data[EN_BIT]                = en_i;
            rd_data[STROBE_LSB +: NUM_CH]  = pend_i;
        end
        if (rd_addr == ADDR_W'(FORCE_ADDR)) begin
            rd_data[NUM_CH-1:0] = force_i;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(word_addr(WORK_BASE, c, IDX_CFG)))  rd_data = work_i[c].cfg;
            if (rd_addr == ADDR_W'(word_addr(WORK_BASE, c, IDX_RES)))  rd_data = work_i[c].res;
            if (rd_addr == ADDR_W'(word_addr(WORK_BASE, c, IDX_SYNC))) rd_data = work_i[c].sync;
            if (rd_addr == ADDR_W'(word_addr(SHAD_BASE, c, IDX_CFG)))  rd_data = shad_i[c].cfg;
            if (rd_addr == ADDR_W'(word_addr(SHAD_BASE, c, IDX_RES)))  rd_data = shad_i[c].res;
            if (rd_addr == ADDR_W'(word_addr(SHAD_BASE, c, IDX_SYNC))) rd_data = shad_i[c].sync;
        end
    end

endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shcfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    input  logic [NUM_CH-1:0]    eof_i,
    output logic [NUM_CH*32-1:0] sh_cfg_o,
    output logic [NUM_CH*32-1:0] sh_res_o,
    output logic [NUM_CH*32-1:0] sh_sync_o
);

    logic                  en_w;
    logic                  srst_w;
    logic [NUM_CH-1:0]     force_w;
    logic [NUM_CH-1:0]     strobe_w;
    logic [NUM_CH-1:0]     pend_w;
    cfg_set_t [NUM_CH-1:0] work_w;
    cfg_set_t [NUM_CH-1:0] shad_w;

    shcfg_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en_o     (en_w),
        .force_o  (force_w),
        .srst_o   (srst_w),
        .strobe_o (strobe_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        shcfg_chan #(.CH_IDX(c), .ADDR_W(ADDR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst_i   (srst_w),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .strobe_i (strobe_w[c]),
            .force_i  (force_w[c]),
            .en_i     (en_w),
            .eof_i    (eof_i[c]),
            .work_o   (work_w[c]),
            .shad_o   (shad_w[c]),
            .pend_o   (pend_w[c])
        );
        assign sh_cfg_o[c*32 +: 32]  = shad_w[c].cfg;
        assign sh_res_o[c*32 +: 32]  = shad_w[c].res;
        assign sh_sync_o[c*32 +: 32] = shad_w[c].sync;
    end

    shcfg_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rdmux (
        .rd_addr (rd_addr),
        .en_i    (en_w),
        .force_i (force_w),
        .pend_i  (pend_w),
        .work_i  (work_w),
        .shad_i  (shad_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/shcfg_chk.sv
module shcfg_chk #(
    parameter int NUM_CH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 srst_i,
    input logic                 en_i,
    input logic [NUM_CH-1:0]    strobe_i,
    input logic [NUM_CH-1:0]    force_i,
    input logic [NUM_CH-1:0]    eof_i,
    input logic [NUM_CH-1:0]    pend_i,
    input logic [NUM_CH*32-1:0] sh_cfg_i
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_SHADOW_ONLY_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(pend_i[c]) && !$past(srst_i)) |-> $stable(sh_cfg_i[c*32 +: 32])); // R6

        AST_PEND_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_i[c] && !strobe_i[c]) |=> !pend_i[c]); // R4

        AST_EOF_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_i[c] && en_i && eof_i[c] && !strobe_i[c] && !srst_i) |=> !pend_i[c]); // R6

        AST_FORCE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_i[c] && en_i && force_i[c] && !strobe_i[c] && !srst_i) |=> !pend_i[c]); // R8

        AST_DISABLED_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_i[c] && !en_i && !srst_i) |=> pend_i[c]); // R9
    end

    AST_SRST_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (pend_i == '0 && sh_cfg_i == '0 && !en_i && force_i == '0)); // R10

endmodule

bind shadow_cfg_regs shcfg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_i   (srst_w),
    .en_i     (en_w),
    .strobe_i (strobe_w),
    .force_i  (force_w),
    .eof_i    (eof_i),
    .pend_i   (pend_w),
    .sh_cfg_i (sh_cfg_o)
);

// File: tb/shadow_cfg_regs_bench.sv
module shadow_cfg_regs_bench;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [ADDR_W-1:0]    wr_addr = '0;
    logic [31:0]          wr_data = '0;
    logic [ADDR_W-1:0]    rd_addr = '0;
    logic [31:0]          rd_data;
    logic [NUM_CH-1:0]    eof_i = '0;
    logic [NUM_CH*32-1:0] sh_cfg_o, sh_res_o, sh_sync_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [ADDR_W-1:0] addr_q[$];
    logic [31:0]       exp_q[$];
    string             tag_q[$];

    always #2 clk = ~clk;

    shadow_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_shadow_cfg_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .eof_i     (eof_i),
        .sh_cfg_o  (sh_cfg_o),
        .sh_res_o  (sh_res_o),
        .sh_sync_o (sh_sync_o)
    );

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: present address and queue the expected word
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_addr = a;
        addr_q.push_back(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic eof(input int c);
        @(negedge clk);
        eof_i[c] = 1'b1;
        @(negedge clk);
        eof_i = '0;
    endtask

    // monitor: compare a quarter period after each negative edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [ADDR_W-1:0] a;
                logic [31:0]       e;
                string             t;
                a = addr_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", t, a, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h10, 32'h0, "R1");
        rd(8'h40, 32'h0, "R1");
        rd(8'h01, 32'h0, "R1");

        // R2 field masks
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'hFF00_00FF, "R2");
        wr(8'h12, 32'hFFFF_FFFF);
        rd(8'h12, 32'h00FF_FFFF, "R2");
        wr(8'h11, 32'h01E0_0280);
        rd(8'h11, 32'h01E0_0280, "R2");

        // R3 shadow write ignored
        wr(8'h40, 32'h1234_5678);
        rd(8'h40, 32'h0, "R3");

        // R4 strobe without enable
        wr(8'h00, 32'h0000_0100);
        rd(8'h00, 32'h0, "R4");
        eof(0);
        rd(8'h40, 32'h0, "R4");

        // R5 accepted strobe
        wr(8'h00, 32'h0000_0101);
        rd(8'h00, 32'h0000_0101, "R5");
        // R7 write while pending
        wr(8'h10, 32'h2A00_00A9);
        // R6 other channel's eof does nothing
        eof(1);
        rd(8'h40, 32'h0, "R6");
        rd(8'h00, 32'h0000_0101, "R6");
        eof(0);
        rd(8'h40, 32'h2A00_00A9, "R7");
        rd(8'h41, 32'h01E0_0280, "R7");
        rd(8'h42, 32'h00FF_FFFF, "R7");
        rd(8'h00, 32'h0000_0001, "R6");

        // R8 force copies without eof
        wr(8'h01, 32'h0000_0004);
        wr(8'h18, 32'h0000_002D);
        wr(8'h00, 32'h0000_0401);
        rd(8'h48, 32'h0000_002D, "R8");
        rd(8'h00, 32'h0000_0001, "R8");
        rd(8'h01, 32'h0000_0004, "R8");

        // R9 disable stalls a pending request
        wr(8'h01, 32'h0);
        wr(8'h1C, 32'h0000_0077);
        wr(8'h00, 32'h0000_0801);
        wr(8'h00, 32'h0000_0000);
        eof(3);
        rd(8'h4C, 32'h0, "R9");
        rd(8'h00, 32'h0000_0800, "R9");
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, 32'h0000_0801, "R9");
        eof(3);
        rd(8'h4C, 32'h0000_0077, "R9");

        // R6 two channels pending, each copies on its own eof
        wr(8'h14, 32'h0000_0011);
        wr(8'h1C, 32'h0000_0055);
        wr(8'h00, 32'h0000_0A01);
        eof(3);
        rd(8'h4C, 32'h0000_0055, "R6");
        rd(8'h44, 32'h0, "R6");
        eof(1);
        rd(8'h44, 32'h0000_0011, "R6");

        // R10 soft reset with strobes in the same write
        wr(8'h01, 32'h0000_000F);
        wr(8'h14, 32'h0000_0022);
        wr(8'h00, 32'h0000_0F03);
        rd(8'h00, 32'h0, "R10");
        rd(8'h01, 32'h0, "R10");
        rd(8'h10, 32'h0, "R10");
        rd(8'h40, 32'h0, "R10");
        rd(8'h44, 32'h0, "R10");
        rd(8'h48, 32'h0, "R10");
        rd(8'h41, 32'h0, "R10");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule